// File: doc/BRIEF.md
# Host Flag and Receive Word Mailbox

This block sits between an 8-bit host bus and a 24-bit processor register bus. Each side has a control register it writes and a status register it reads. The host sets two general flags and a pair of transfer-mode bits. The processor sees the two flags and a single "DMA enabled" indication. In the other direction, the processor sets two flags of its own, and the host sees them.

For inbound data, the host writes three byte-wide transmit registers. Writing the last of them (the low byte) hands the word over. As soon as the processor's receive register has been emptied, the three bytes move into it as one 24-bit word. Empty and full flags on both sides pace the exchange. All state is updated on the rising clock edge. Read data is combinational from the current register contents and reads zero whenever the matching read strobe is low.

Top module: `hmb_mailbox`

## Requirements
- R1: The host control register, at byte address 0, reads back the last byte written with bit 2 forced to 0. Its bit meanings are: bit 7 init, bit 6 mode-1, bit 5 mode-0, bit 4 flag-1, bit 3 flag-0, bit 1 transmit-request, bit 0 receive-request. A host read of any address other than 0 or 2 returns 0, and any host read with `host_rd` low returns 0.
- R2: The processor status register (select 1) is laid out as follows. Bit 0 is the receive-full flag. Bits 4 and 3 mirror host control bits 4 and 3. Bits 6, 5, 2 and 1, and bits 23 to 8, read 0. Select 3 reads 0.
- R3: The DMA status bit appears as processor status bit 7 and as host status bit 6. It is 1 one clock after host control bit 6 or bit 5 is 1. It is 0 one clock after both of those bits are 0.
- R4: While `soft_rst`, `indiv_rst` or `stop_req` is high at a clock edge, the DMA status bit is 0 after that edge, whatever the mode bits hold.
- R5: The processor control register (select 0) keeps bits 4 to 0 as written, and its bits 23 to 5 read 0. Its bits 4 and 3 appear as host status bits 4 and 3.
- R6: The host status register, at byte address 2, holds the following bits. Bit 7 is transmit-request AND transmit-empty. Bit 2 is transmit-empty AND NOT receive-full. Bit 1 is transmit-empty. Bits 5 and 0 read 0.
- R7: A host write to address 7 (the low transmit byte) clears transmit-empty after the edge. Writes to address 5 (high byte) and address 6 (middle byte) leave it unchanged.
- R8: At an edge where transmit-empty is 0 and receive-full is 0, the receive register (select 2) loads {byte at 5, byte at 6, byte at 7}, and transmit-empty and receive-full both become 1.
- R9: A processor read at select 2 clears receive-full. While receive-full is 1, the receive register keeps its value.
- R10: A low-byte write at the same edge as a move has the following effect. The move carries the bytes held before that edge. Transmit-empty stays 0, so the new word moves once receive-full has been cleared.
- R11: After the synchronous reset, all of the following hold. Transmit-empty is 1 and receive-full is 0. Both control registers, all flags, the DMA bit, the transmit bytes and the receive register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset request, clears DMA status |
| indiv_rst | input | 1 | Per-block reset request, clears DMA status |
| stop_req | input | 1 | Stop condition, clears DMA status |
| host_addr | input | 3 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| proc_sel | input | 2 | Processor register select (0 control, 1 status, 2 receive) |
| proc_wr | input | 1 | Processor write strobe |
| proc_rd | input | 1 | Processor read strobe |
| proc_wdata | input | 24 | Processor write data |
| proc_rdata | output | 24 | Processor read data |

## Verification
Two functions can land on the same edge. One is the host's write of the low transmit byte. The other is the automatic move of the pending word into an empty receive register, which happens whenever both flags are 0. A directed sequence forces this meeting: it writes the three bytes, then writes a new low byte on exactly the next cycle. It then checks that the word received holds the old low byte, that transmit-empty stays 0, and that after a processor read the second word carries the new low byte. Random traffic with frequent low-byte writes and receive reads hits the same meeting repeatedly, and the bench compares every read against a cycle model built from the requirements.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    localparam int unsigned HOST_DW  = 8;
    localparam int unsigned HOST_AW  = 3;
    localparam int unsigned NUM_TX   = 3;
    localparam int unsigned PROC_DW  = 24;
    localparam int unsigned PSEL_W   = 2;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned PCTL_W   = 5;

    localparam int unsigned OFF_CTRL = 0;
    localparam int unsigned OFF_STAT = 2;
    localparam int unsigned OFF_TX0  = 5;

    localparam logic [PSEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [PSEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [PSEL_W-1:0] SEL_RX   = 2'd2;

    localparam int unsigned CTRL_ZERO_BIT = 2;
    localparam logic [HOST_DW-1:0] CTRL_MASK = ~(HOST_DW'(1) << CTRL_ZERO_BIT);

    // host-written control byte, bit 7 down to bit 0
    typedef struct packed {
        logic init;
        logic mode1;
        logic mode0;
        logic flag1;
        logic flag0;
        logic zero;
        logic tx_req;
        logic rx_req;
    } host_ctrl_t;

    // processor-written control, bit 4 down to bit 0
    typedef struct packed {
        logic flag3;
        logic flag2;
        logic cmd_ie;
        logic tx_ie;
        logic rx_ie;
    } proc_ctrl_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
    } xfer_flags_t;

    function automatic logic [STAT_W-1:0] host_status(
        input host_ctrl_t  hc,
        input proc_ctrl_t  pc,
        input logic        dma,
        input xfer_flags_t fl
    );
        logic [STAT_W-1:0] s;
        s    = '0;
        s[7] = hc.tx_req & fl.tx_empty;
        s[6] = dma;
        s[4] = pc.flag3;
        s[3] = pc.flag2;
        s[2] = fl.tx_empty & ~fl.rx_full;
        s[1] = fl.tx_empty;
        return s;
    endfunction

    function automatic logic [STAT_W-1:0] proc_status(
        input host_ctrl_t  hc,
        input logic        dma,
        input xfer_flags_t fl
    );
        logic [STAT_W-1:0] s;
        s    = '0;
        s[7] = dma;
        s[4] = hc.flag1;
        s[3] = hc.flag0;
        s[0] = fl.rx_full;
        return s;
    endfunction

endpackage

// File: rtl/hmb_host_side.sv
module hmb_host_side
    import hmb_pkg::*;
#(
    parameter int unsigned AW   = HOST_AW,
    parameter int unsigned DW   = HOST_DW,
    parameter int unsigned NTX  = NUM_TX,
    parameter int unsigned CTRL = OFF_CTRL,
    parameter int unsigned TX0  = OFF_TX0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic [DW-1:0]     wdata,
    output host_ctrl_t        ctrl,
    output logic [DW*NTX-1:0] tx_word,
    output logic              low_wr
);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL);
    localparam logic [AW-1:0] LOW_A  = AW'(TX0 + NTX - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr && addr == CTRL_A) begin
            ctrl <= host_ctrl_t'(wdata & CTRL_MASK);
        end
    end

    // byte 0 (lowest address) is the most significant part of the word
    for (genvar b = 0; b < NTX; b++) begin : g_txbyte
        localparam logic [AW-1:0] MY_A = AW'(TX0 + b);
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr && addr == MY_A) begin
                q <= wdata;
            end
        end
        assign tx_word[(NTX-1-b)*DW +: DW] = q;
    end

    assign low_wr = wr && (addr == LOW_A);

endmodule

// File: rtl/hmb_xfer.sv
module hmb_xfer
    import hmb_pkg::*;
#(
    parameter int unsigned W = HOST_DW * NUM_TX
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tx_word,
    input  logic         low_wr,
    input  logic         rx_rd,
    output logic [W-1:0] rx_word,
    output xfer_flags_t  flags
);
    logic move;
    assign move = !flags.tx_empty && !flags.rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word        <= '0;
            flags.tx_empty <= 1'b1;
            flags.rx_full  <= 1'b0;
        end else begin
            if (move) begin
                rx_word <= tx_word;
            end
            // a new low byte outranks the empty flag raised by a move
            if (low_wr) begin
                flags.tx_empty <= 1'b0;
            end else if (move) begin
                flags.tx_empty <= 1'b1;
            end
            if (move) begin
                flags.rx_full <= 1'b1;
            end else if (rx_rd) begin
                flags.rx_full <= 1'b0;
            end
        end
    end

    // R7
    low_write_empties_chk: assert property (@(posedge clk) disable iff (rst)
        low_wr |=> !flags.tx_empty);

    // R8
    move_loads_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags.tx_empty && !flags.rx_full) |=> (flags.rx_full && rx_word == $past(tx_word)));

    // R9
    full_holds_word_chk: assert property (@(posedge clk) disable iff (rst)
        flags.rx_full |=> $stable(rx_word));

    // R9
    read_drains_full_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.rx_full && rx_rd) |=> !flags.rx_full);

endmodule

// File: rtl/hmb_dma_stat.sv
module hmb_dma_stat #(
    parameter int unsigned NCLR = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic [NCLR-1:0] clr,
    output logic            dma
);
    always_ff @(posedge clk) begin
        if (rst || (|clr)) begin
            dma <= 1'b0;
        end else begin
            dma <= |mode;
        end
    end

    // R4
    clear_forces_dma_low_chk: assert property (@(posedge clk) disable iff (rst)
        (|clr) |=> !dma);

endmodule

// File: rtl/hmb_proc_side.sv
module hmb_proc_side
    import hmb_pkg::*;
#(
    parameter int unsigned PW = PROC_DW,
    parameter int unsigned SW = PSEL_W,
    parameter int unsigned RW = HOST_DW * NUM_TX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    input  logic          wr,
    input  logic          rd,
    input  logic [PW-1:0] wdata,
    input  host_ctrl_t    hctrl,
    input  logic          dma,
    input  xfer_flags_t   flags,
    input  logic [RW-1:0] rx_word,
    output proc_ctrl_t    pctrl,
    output logic          rx_rd,
    output logic [PW-1:0] rdata
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[PW-1:PCTL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pctrl <= '0;
        end else if (wr && sel == SEL_CTRL) begin
            pctrl <= proc_ctrl_t'(wdata[PCTL_W-1:0]);
        end
    end

    assign rx_rd = rd && (sel == SEL_RX);

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_CTRL: rdata = PW'(pctrl);
                SEL_STAT: rdata = PW'(proc_status(hctrl, dma, flags));
                SEL_RX:   rdata = PW'(rx_word);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
    import hmb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               indiv_rst,
    input  logic               stop_req,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic [PSEL_W-1:0]  proc_sel,
    input  logic               proc_wr,
    input  logic               proc_rd,
    input  logic [PROC_DW-1:0] proc_wdata,
    output logic [PROC_DW-1:0] proc_rdata
);
    localparam int unsigned WORD_W = HOST_DW * NUM_TX;
    localparam logic [HOST_AW-1:0] CTRL_A = HOST_AW'(OFF_CTRL);
    localparam logic [HOST_AW-1:0] STAT_A = HOST_AW'(OFF_STAT);

    host_ctrl_t        hctrl;
    proc_ctrl_t        pctrl;
    xfer_flags_t       flags;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rx_word;
    logic              low_wr;
    logic              rx_rd;
    logic              dma;

    hmb_host_side #(
        .AW(HOST_AW), .DW(HOST_DW), .NTX(NUM_TX), .CTRL(OFF_CTRL), .TX0(OFF_TX0)
    ) u_host (
        .clk(clk), .rst(rst), .addr(host_addr), .wr(host_wr), .wdata(host_wdata),
        .ctrl(hctrl), .tx_word(tx_word), .low_wr(low_wr)
    );

    hmb_xfer #(.W(WORD_W)) u_xfer (
        .clk(clk), .rst(rst), .tx_word(tx_word), .low_wr(low_wr), .rx_rd(rx_rd),
        .rx_word(rx_word), .flags(flags)
    );

    hmb_dma_stat #(.NCLR(3)) u_dma (
        .clk(clk), .rst(rst), .mode({hctrl.mode1, hctrl.mode0}),
        .clr({soft_rst, indiv_rst, stop_req}), .dma(dma)
    );

    hmb_proc_side #(.PW(PROC_DW), .SW(PSEL_W), .RW(WORD_W)) u_proc (
        .clk(clk), .rst(rst), .sel(proc_sel), .wr(proc_wr), .rd(proc_rd),
        .wdata(proc_wdata), .hctrl(hctrl), .dma(dma), .flags(flags),
        .rx_word(rx_word), .pctrl(pctrl), .rx_rd(rx_rd), .rdata(proc_rdata)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (host_addr)
                CTRL_A:  host_rdata = hctrl;
                STAT_A:  host_rdata = host_status(hctrl, pctrl, dma, flags);
                default: host_rdata = '0;
            endcase
        end
    end

    // R10
    collision_keeps_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!flags.tx_empty && !flags.rx_full && low_wr) |=> (!flags.tx_empty && flags.rx_full));

    // R3
    mode_clear_drops_dma_chk: assert property (@(posedge clk) disable iff (rst)
        (!hctrl.mode1 && !hctrl.mode0) |=> !dma);

endmodule

// File: tb/tb_hmb_mailbox.sv
module tb_hmb_mailbox;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 0, indiv_rst = 0, stop_req = 0;
    logic [2:0]  host_addr = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [7:0]  host_wdata = 0;
    logic [7:0]  host_rdata;
    logic [1:0]  proc_sel = 0;
    logic        proc_wr = 0, proc_rd = 0;
    logic [23:0] proc_wdata = 0;
    logic [23:0] proc_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state
    logic [7:0]  m_hc;
    logic [4:0]  m_pc;
    logic [7:0]  m_th, m_tm, m_tl;
    logic [23:0] m_rx;
    logic        m_txe, m_full, m_dma;

    always #(CLK_P/2) clk = ~clk;

    hmb_mailbox dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .indiv_rst(indiv_rst),
        .stop_req(stop_req), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .proc_sel(proc_sel), .proc_wr(proc_wr), .proc_rd(proc_rd),
        .proc_wdata(proc_wdata), .proc_rdata(proc_rdata)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_host();
        if (!host_rd) return 8'h00;
        if (host_addr == 3'd0) return m_hc;
        if (host_addr == 3'd2)
            return {m_hc[1] & m_txe, m_dma, 1'b0, m_pc[4], m_pc[3],
                    m_txe & ~m_full, m_txe, 1'b0};
        return 8'h00;
    endfunction

    function automatic logic [23:0] exp_proc();
        if (!proc_rd) return 24'h0;
        case (proc_sel)
            2'd0: return {19'h0, m_pc};
            2'd1: return {16'h0, m_dma, 2'b00, m_hc[4], m_hc[3], 2'b00, m_full};
            2'd2: return m_rx;
            default: return 24'h0;
        endcase
    endfunction

    function automatic string host_tag();
        return (host_addr == 3'd2) ? "R6" : "R1";
    endfunction

    function automatic string proc_tag();
        case (proc_sel)
            2'd0: return "R5";
            2'd2: return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic model_edge();
        logic mv;
        if (rst) begin
            m_hc = 0; m_pc = 0; m_th = 0; m_tm = 0; m_tl = 0; m_rx = 0;
            m_txe = 1; m_full = 0; m_dma = 0;
            return;
        end
        mv = !m_txe && !m_full;
        m_dma = (soft_rst | indiv_rst | stop_req) ? 1'b0 : (m_hc[6] | m_hc[5]);
        if (mv) begin
            m_rx = {m_th, m_tm, m_tl};
            m_txe = 1; m_full = 1;
        end else if (proc_rd && proc_sel == 2'd2) begin
            m_full = 0;
        end
        if (host_wr) begin
            case (host_addr)
                3'd0: m_hc = host_wdata & 8'hFB;
                3'd5: m_th = host_wdata;
                3'd6: m_tm = host_wdata;
                3'd7: begin m_tl = host_wdata; m_txe = 0; end
                default: ;
            endcase
        end
        if (proc_wr && proc_sel == 2'd0) m_pc = proc_wdata[4:0];
    endtask

    // inputs are already set (after a falling edge)
    task automatic tick();
        #1;
        check(host_tag(), {16'h0, host_rdata}, {16'h0, exp_host()});
        check(proc_tag(), proc_rdata, exp_proc());
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; proc_wr = 0; proc_rd = 0;
        soft_rst = 0; indiv_rst = 0; stop_req = 0;
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        idle(); host_addr = a; host_wr = 1; host_wdata = d; tick();
    endtask

    task automatic peek_host(input logic [2:0] a);
        idle(); host_addr = a; host_rd = 1; #1;
    endtask

    task automatic peek_proc(input logic [1:0] s);
        idle(); proc_sel = s; proc_rd = 1; #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1; tick(); tick();
        rst = 0;

        // R11 reset state
        peek_host(3'd2); check("R11", {16'h0, host_rdata}, 24'h000006);
        peek_host(3'd0); check("R11", {16'h0, host_rdata}, 24'h0);
        peek_proc(2'd1); check("R11", proc_rdata, 24'h0);
        peek_proc(2'd2); check("R11", proc_rdata, 24'h0);
        peek_proc(2'd0); check("R11", proc_rdata, 24'h0);

        // R1 bit 2 forced to 0; R3 DMA follows mode bits one clock later
        hwrite(3'd0, 8'hFF);
        peek_host(3'd0); check("R1", {16'h0, host_rdata}, 24'h0000FB);
        peek_proc(2'd1); check("R3", proc_rdata, 24'h000018);
        tick();
        peek_proc(2'd1); check("R3", proc_rdata, 24'h000098);
        peek_host(3'd2); check("R3", {16'h0, host_rdata}, 24'h0000C6);

        // R4 each clear source forces DMA low
        idle(); stop_req = 1; tick();
        peek_proc(2'd1); check("R4", proc_rdata, 24'h000018);
        tick();
        peek_proc(2'd1); check("R4", proc_rdata, 24'h000098);
        idle(); soft_rst = 1; tick();
        peek_host(3'd2); check("R4", {16'h0, host_rdata[6]}, 24'h0);
        idle(); indiv_rst = 1; tick();
        peek_proc(2'd1); check("R4", proc_rdata[7], 1'b0);
        hwrite(3'd0, 8'h00); tick();
        peek_proc(2'd1); check("R3", proc_rdata, 24'h0);

        // R5 processor control flags to host status, upper bits dropped
        idle(); proc_sel = 2'd0; proc_wr = 1; proc_wdata = 24'hFFFF_F8; tick();
        peek_proc(2'd0); check("R5", proc_rdata, 24'h000018);
        peek_host(3'd2); check("R5", {16'h0, host_rdata}, 24'h00001E);

        // R7 high and middle writes keep empty, low write clears it
        hwrite(3'd5, 8'hA1); peek_host(3'd2); check("R7", host_rdata[1], 1'b1);
        hwrite(3'd6, 8'hB2); peek_host(3'd2); check("R7", host_rdata[1], 1'b1);
        // R10 collision: low write now, then another low write on the move edge
        hwrite(3'd7, 8'hC3); peek_host(3'd2); check("R7", host_rdata[1], 1'b0);
        hwrite(3'd7, 8'hD4);
        peek_proc(2'd2); check("R10", proc_rdata, 24'hA1B2C3);
        peek_host(3'd2); check("R10", {16'h0, host_rdata}, 24'h000018);
        peek_proc(2'd1); check("R9", proc_rdata[0], 1'b1);
        // R9 read drains full; pending word moves the edge after
        idle(); proc_sel = 2'd2; proc_rd = 1; tick();
        peek_proc(2'd1); check("R9", proc_rdata[0], 1'b0);
        tick();
        peek_proc(2'd2); check("R10", proc_rdata, 24'hA1B2D4);
        peek_host(3'd2); check("R8", {16'h0, host_rdata}, 24'h00001A);
        // R9 word held while full even when new bytes arrive
        hwrite(3'd5, 8'h11); hwrite(3'd7, 8'h33); tick();
        peek_proc(2'd2); check("R9", proc_rdata, 24'hA1B2D4);
        // R6 request bit reflects transmit-empty
        hwrite(3'd0, 8'h02);
        peek_host(3'd2); check("R6", host_rdata[7], 1'b0);
        idle(); proc_sel = 2'd2; proc_rd = 1; tick(); tick();
        peek_proc(2'd2); check("R8", proc_rdata, 24'h11B233);
        peek_host(3'd2); check("R6", host_rdata[7], 1'b1);
        // R1 unused addresses read 0, and no read strobe reads 0
        peek_host(3'd4); check("R1", {16'h0, host_rdata}, 24'h0);
        idle(); host_addr = 3'd0; #1; check("R1", {16'h0, host_rdata}, 24'h0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            host_addr  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) host_addr = 3'd7;
            host_wr    = ($urandom_range(0, 9) < 3);
            host_rd    = ($urandom_range(0, 9) < 7);
            host_wdata = 8'($urandom);
            proc_sel   = 2'($urandom_range(0, 3));
            proc_wr    = ($urandom_range(0, 9) < 2);
            proc_rd    = ($urandom_range(0, 9) < 4);
            proc_wdata = 24'($urandom);
            soft_rst   = ($urandom_range(0, 39) == 0);
            indiv_rst  = ($urandom_range(0, 39) == 0);
            stop_req   = ($urandom_range(0, 39) == 0);
            rst        = ($urandom_range(0, 499) == 0);
            tick();
        end
        rst = 0;
        idle(); tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule